// File: doc/BRIEF.md
# Flash Program and Erase Sequencer

This block turns whole write and erase requests into the sequence of single commands that a serial flash needs, and hands those commands one at a time to a lower command engine. A write request carries a start address and a byte count, and its data arrives on a byte stream. The sequencer cuts the data into program commands of at most four bytes. No program command runs past the end of a 256-byte page. Each program command is wrapped in a write-enable before it and a status poll after it. An erase request walks its range in sector steps. Each sector gets a write-enable, a sector-erase command and a status poll.

Status polling repeats until the flash reports that its write is finished. The sequencer waits a programmable number of cycles before each status read. A request that would reach past the end of the device is refused with no flash activity. A zero-length request completes at once. Completion of each request is shown by a one-cycle pulse, together with an error flag for refused requests.

The command engine sees a valid/ready handshake carrying opcode, address, data and byte counts. It returns a one-cycle completion pulse with the received status byte.

Top module: `flash_pe_seq`

## Requirements
- R1: A write is cut into program commands at ascending addresses. Each command's length is the smallest of three values: the bytes remaining, 4, and 256 minus (address mod 256). No command crosses a 256-byte page.
- R2: Every program command (opcode 0x02) and every sector-erase command (opcode 0xD8) comes directly after a write-enable command (opcode 0x06, transmit count 1), with no other command between them.
- R3: A program command carries the address of its first byte and a transmit count of length plus 4. Its data word holds the bytes little-endian: first byte in bits [7:0], unused upper bytes zero. A command's fields stay stable while it waits for ready.
- R4: After every program or erase command, read-status (opcode 0x05, transmit 1, receive 1) is issued repeatedly. Polling stops when bit 0 of the returned status byte is 0. Bits [7:1] are ignored. The next command follows only after that.
- R5: Suppose the engine's completion pulse for a program, erase or busy status read is high in cycle n. The next status read then raises cmd_valid in cycle n + poll_wait + 2.
- R6: An erase issues one sector-erase command at the start address. It then issues one at each further sector-size step, while the address stays below start plus length.
- R7: A request with address plus length greater than the device size is refused. done and err are both high in the cycle after the request is taken, and no command is issued.
- R8: A zero-length write or erase completes with done in the cycle after it is taken. err stays low and no command is issued.
- R9: After reset, done, err and cmd_valid are low and req_ready is high. done is high for exactly one cycle per request.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| req_valid | input | 1 | Request strobe, taken while req_ready is high |
| req_erase | input | 1 | 1 = erase request, 0 = write request |
| req_addr | input | ADDR_W | Start byte address |
| req_len | input | ADDR_W | Length in bytes |
| req_ready | output | 1 | Sequencer idle and able to take a request |
| wr_valid | input | 1 | Write byte valid |
| wr_data | input | 8 | Write byte |
| wr_ready | output | 1 | Sequencer takes a write byte this cycle |
| poll_wait | input | GAP_W | Extra wait cycles before each status read |
| cmd_valid | output | 1 | Command offered to the engine |
| cmd_ready | input | 1 | Engine takes the command |
| cmd_opcode | output | 8 | Command opcode |
| cmd_addr | output | ADDR_W | Command address |
| cmd_data | output | 32 | Program data, little-endian |
| cmd_txcnt | output | 4 | Bytes to transmit, opcode included |
| cmd_rxcnt | output | 3 | Bytes to receive |
| eng_done | input | 1 | Engine completion pulse |
| eng_rdata | input | 8 | Status byte returned with eng_done |
| done | output | 1 | Request complete, one-cycle pulse |
| err | output | 1 | Request refused, high with done |

## Verification
Refused and zero-length requests must show done, and err where it applies, at the first falling edge after the request strobe is removed. The bench samples exactly there and counts any extra delay as a mismatch. Command results are checked against bench-computed chunk lists once done arrives, so handshake timing does not matter for them. The only other exact timing is the poll gap. The bench timestamps each completion pulse and the rising edge of each status-read cmd_valid, and requires the two to be poll_wait + 2 cycles apart. The cycle after done is sampled to confirm the pulse has ended.

// File: rtl/flash_pe_seq.sv
module flash_pe_seq #(
  parameter int DEV_BYTES  = 4194304,
  parameter int SECT_BYTES = 65536,
  parameter int PAGE_BYTES = 256,
  parameter int ADDR_W     = 24,
  parameter int GAP_W      = 8
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              req_valid,
  input  logic              req_erase,
  input  logic [ADDR_W-1:0] req_addr,
  input  logic [ADDR_W-1:0] req_len,
  output logic              req_ready,
  input  logic              wr_valid,
  input  logic [7:0]        wr_data,
  output logic              wr_ready,
  input  logic [GAP_W-1:0]  poll_wait,
  output logic              cmd_valid,
  input  logic              cmd_ready,
  output logic [7:0]        cmd_opcode,
  output logic [ADDR_W-1:0] cmd_addr,
  output logic [31:0]       cmd_data,
  output logic [3:0]        cmd_txcnt,
  output logic [2:0]        cmd_rxcnt,
  input  logic              eng_done,
  input  logic [7:0]        eng_rdata,
  output logic              done,
  output logic              err
);
  localparam int PG_W = $clog2(PAGE_BYTES);
  localparam logic [7:0] OP_WREN = 8'h06;
  localparam logic [7:0] OP_PROG = 8'h02;
  localparam logic [7:0] OP_SERA = 8'hD8;
  localparam logic [7:0] OP_RDSR = 8'h05;

  typedef enum logic [3:0] {
    S_IDLE, S_LOAD, S_WREN, S_WREN_W, S_OP, S_OP_W, S_GAP, S_POLL, S_POLL_W
  } st_t;

  st_t               st;
  logic              erase_r;
  logic [ADDR_W-1:0] addr_r, rem_r;
  logic [ADDR_W:0]   end_r;
  logic [31:0]       data_r;
  logic [1:0]        bcnt;
  logic [GAP_W-1:0]  gap_r;
  logic              done_r, err_r;
  logic [PG_W:0]     room;
  logic [2:0]        clen;
  logic [ADDR_W:0]   req_end, sect_nxt;

  assign req_end  = {1'b0, req_addr} + {1'b0, req_len};
  assign sect_nxt = {1'b0, addr_r} + (ADDR_W+1)'(SECT_BYTES);
  assign room     = (PG_W+1)'(PAGE_BYTES) - {1'b0, addr_r[PG_W-1:0]};

  always_comb begin
    clen = 3'd4;
    if (rem_r < ADDR_W'(4)) clen = rem_r[2:0];
    if (room < (PG_W+1)'(clen)) clen = room[2:0];
  end

  assign req_ready  = (st == S_IDLE);
  assign wr_ready   = (st == S_LOAD);
  assign cmd_valid  = (st == S_WREN) || (st == S_OP) || (st == S_POLL);
  assign cmd_opcode = (st == S_WREN) ? OP_WREN : (st == S_POLL) ? OP_RDSR :
                      erase_r ? OP_SERA : OP_PROG;
  assign cmd_txcnt  = (st != S_OP) ? 4'd1 : erase_r ? 4'd4 : 4'(clen) + 4'd4;
  assign cmd_rxcnt  = (st == S_POLL) ? 3'd1 : 3'd0;
  assign cmd_addr   = addr_r;
  assign cmd_data   = data_r;
  assign done       = done_r;
  assign err        = err_r;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      st <= S_IDLE; erase_r <= 1'b0; addr_r <= '0; rem_r <= '0; end_r <= '0;
      data_r <= '0; bcnt <= '0; gap_r <= '0; done_r <= 1'b0; err_r <= 1'b0;
    end else begin
      done_r <= 1'b0;
      err_r  <= 1'b0;
      case (st)
        S_IDLE: if (req_valid) begin
          erase_r <= req_erase;
          addr_r  <= req_addr;
          rem_r   <= req_len;
          end_r   <= req_end;
          data_r  <= '0;
          bcnt    <= '0;
          if (req_end > (ADDR_W+1)'(DEV_BYTES)) begin
            done_r <= 1'b1;
            err_r  <= 1'b1;
          end else if (req_len == '0) done_r <= 1'b1;
          else st <= req_erase ? S_WREN : S_LOAD;
        end
        S_LOAD: if (wr_valid) begin
          data_r[{bcnt, 3'b000} +: 8] <= wr_data;
          bcnt <= bcnt + 2'd1;
          if ({1'b0, bcnt} == clen - 3'd1) st <= S_WREN;
        end
        S_WREN:   if (cmd_ready) st <= S_WREN_W;
        S_WREN_W: if (eng_done)  st <= S_OP;
        S_OP:     if (cmd_ready) st <= S_OP_W;
        S_OP_W: if (eng_done) begin
          gap_r <= poll_wait;
          st    <= S_GAP;
        end
        S_GAP: if (gap_r == '0) st <= S_POLL;
               else gap_r <= gap_r - 1'b1;
        S_POLL: if (cmd_ready) st <= S_POLL_W;
        S_POLL_W: if (eng_done) begin
          if (eng_rdata[0]) begin
            gap_r <= poll_wait;
            st    <= S_GAP;
          end else if (erase_r) begin
            if (sect_nxt < end_r) begin
              addr_r <= sect_nxt[ADDR_W-1:0];
              st     <= S_WREN;
            end else begin
              done_r <= 1'b1;
              st     <= S_IDLE;
            end
          end else if (rem_r == ADDR_W'(clen)) begin
            done_r <= 1'b1;
            st     <= S_IDLE;
          end else begin
            addr_r <= addr_r + ADDR_W'(clen);
            rem_r  <= rem_r - ADDR_W'(clen);
            data_r <= '0;
            bcnt   <= '0;
            st     <= S_LOAD;
          end
        end
        default: st <= S_IDLE;
      endcase
    end
  end
endmodule

// File: rtl/flash_pe_seq_chk.sv
module flash_pe_seq_chk #(
  parameter int ADDR_W     = 24,
  parameter int PAGE_BYTES = 256
) (
  input logic              clk,
  input logic              rst_n,
  input logic              cmd_valid,
  input logic              cmd_ready,
  input logic [7:0]        cmd_opcode,
  input logic [ADDR_W-1:0] cmd_addr,
  input logic [3:0]        cmd_txcnt,
  input logic              done,
  input logic              err
);
  localparam int PG_W = $clog2(PAGE_BYTES);
  logic [7:0] last_op;
  logic       hs;
  assign hs = cmd_valid && cmd_ready;

  always_ff @(posedge clk) begin
    if (!rst_n) last_op <= 8'h00;
    else if (hs) last_op <= cmd_opcode;
  end

  p_wren_first_r2: assert property (@(posedge clk) disable iff (!rst_n)
    hs && (cmd_opcode == 8'h02 || cmd_opcode == 8'hD8) |-> last_op == 8'h06);

  p_poll_follows_r4: assert property (@(posedge clk) disable iff (!rst_n)
    hs && (last_op == 8'h02 || last_op == 8'hD8) |-> cmd_opcode == 8'h05);

  p_prog_count_r3: assert property (@(posedge clk) disable iff (!rst_n)
    hs && cmd_opcode == 8'h02 |-> cmd_txcnt >= 4'd5 && cmd_txcnt <= 4'd8);

  p_in_page_r1: assert property (@(posedge clk) disable iff (!rst_n)
    hs && cmd_opcode == 8'h02 |->
      ({1'b0, cmd_addr[PG_W-1:0]} + (PG_W+1)'(cmd_txcnt) - (PG_W+1)'(4))
        <= (PG_W+1)'(PAGE_BYTES));

  p_cmd_hold_r3: assert property (@(posedge clk) disable iff (!rst_n)
    cmd_valid && !cmd_ready |=> cmd_valid && $stable(cmd_opcode) && $stable(cmd_addr));

  p_done_pulse_r9: assert property (@(posedge clk) disable iff (!rst_n)
    done |=> !done);

  p_err_done_r7: assert property (@(posedge clk) disable iff (!rst_n)
    err |-> done);
endmodule

bind flash_pe_seq flash_pe_seq_chk #(.ADDR_W(ADDR_W), .PAGE_BYTES(PAGE_BYTES)) u_chk (
  .clk(clk), .rst_n(rst_n), .cmd_valid(cmd_valid), .cmd_ready(cmd_ready),
  .cmd_opcode(cmd_opcode), .cmd_addr(cmd_addr), .cmd_txcnt(cmd_txcnt),
  .done(done), .err(err)
);

// File: tb/flash_pe_seq_bench.sv
module flash_pe_seq_bench;
  localparam int DEV  = 4194304;
  localparam int SECT = 65536;

  logic clk = 1'b0, rst_n = 1'b0;
  logic req_valid = 1'b0, req_erase = 1'b0;
  logic [23:0] req_addr = '0, req_len = '0;
  logic req_ready, wr_ready, cmd_valid, done, err;
  logic wr_valid = 1'b0;
  logic [7:0] wr_data = '0;
  logic [7:0] poll_wait = '0;
  logic cmd_ready = 1'b0, eng_done = 1'b0;
  logic [7:0] eng_rdata = '0;
  logic [7:0] cmd_opcode;
  logic [23:0] cmd_addr;
  logic [31:0] cmd_data;
  logic [3:0] cmd_txcnt;
  logic [2:0] cmd_rxcnt;

  always #5 clk = ~clk;

  flash_pe_seq u_flash_pe_seq (
    .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_erase(req_erase),
    .req_addr(req_addr), .req_len(req_len), .req_ready(req_ready),
    .wr_valid(wr_valid), .wr_data(wr_data), .wr_ready(wr_ready),
    .poll_wait(poll_wait), .cmd_valid(cmd_valid), .cmd_ready(cmd_ready),
    .cmd_opcode(cmd_opcode), .cmd_addr(cmd_addr), .cmd_data(cmd_data),
    .cmd_txcnt(cmd_txcnt), .cmd_rxcnt(cmd_rxcnt), .eng_done(eng_done),
    .eng_rdata(eng_rdata), .done(done), .err(err)
  );

  int n_cmp = 0, n_bad = 0, negc = 0;
  logic [7:0]  sbuf [0:63];
  int s_n = 0, s_i = 0;
  bit s_pend = 0;
  logic [7:0]  lg_op   [0:1023];
  logic [23:0] lg_addr [0:1023];
  logic [31:0] lg_data [0:1023];
  logic [3:0]  lg_tx   [0:1023];
  logic [2:0]  lg_rx   [0:1023];
  int          lg_wip  [0:1023];
  int lg_n = 0;
  bit busy = 0, pv = 0;
  int dly = 0, wip_left = 0, last_done = 0, gap_bad = 0, gap_seen = 0;
  logic [7:0] cur_op = '0;
  logic [31:0] rnd;

  always @(negedge clk) begin
    negc++;
    if (!rst_n) begin
      eng_done = 0; cmd_ready = 0; wr_valid = 0; busy = 0; pv = 0;
    end else begin
      eng_done = 0;
      if (cmd_valid && !pv && cmd_opcode == 8'h05) begin
        gap_seen++;
        if (negc - last_done != int'(poll_wait) + 2) gap_bad++;
      end
      pv = cmd_valid;
      if (busy) begin
        cmd_ready = 0;
        if (dly == 0) begin
          eng_done = 1; last_done = negc; busy = 0;
          if (cur_op == 8'h05) begin
            rnd = $urandom;
            eng_rdata = {rnd[7:1], wip_left > 0};
            if (wip_left > 0) wip_left--;
          end
        end else dly--;
      end else begin
        cmd_ready = ($urandom % 4) != 0;
        if (cmd_valid && cmd_ready && lg_n < 1024) begin
          lg_op[lg_n] = cmd_opcode; lg_addr[lg_n] = cmd_addr; lg_data[lg_n] = cmd_data;
          lg_tx[lg_n] = cmd_txcnt; lg_rx[lg_n] = cmd_rxcnt; lg_wip[lg_n] = 0;
          cur_op = cmd_opcode;
          if (cmd_opcode == 8'h02 || cmd_opcode == 8'hD8) begin
            wip_left = $urandom % 4; lg_wip[lg_n] = wip_left;
          end
          lg_n++;
          busy = 1; dly = $urandom % 3;
        end
      end
      if (s_pend) s_i++;
      wr_valid = (s_i < s_n) && (($urandom % 3) != 0);
      wr_data  = (s_i < 64) ? sbuf[s_i] : 8'h00;
      s_pend   = wr_valid && wr_ready;
    end
  end

  task automatic chk(input bit ok, input string tag, input longint act, input longint exp);
    n_cmp++;
    if (!ok) begin
      n_bad++;
      $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
    end
  endtask

  task automatic run_req(input bit er, input int addr, input int len, output int lat, output bit e);
    lg_n = 0; gap_bad = 0; gap_seen = 0;
    poll_wait = 8'($urandom % 5);
    for (int i = 0; i < 64; i++) sbuf[i] = 8'($urandom);
    s_i = 0; s_pend = 0; s_n = er ? 0 : len;
    @(negedge clk);
    req_valid = 1; req_erase = er; req_addr = 24'(addr); req_len = 24'(len);
    @(negedge clk);
    req_valid = 0; lat = 0;
    while (!done && lat < 20000) begin @(negedge clk); lat++; end
    e = err;
    @(negedge clk);
    chk(done == 0, "R9 done lasts one cycle", done, 0);
  endtask

  task automatic check_polls(inout int idx, inout int e4, input int w);
    for (int j = 0; j <= w; j++) begin
      if (idx + j >= lg_n || lg_op[idx+j] !== 8'h05 || lg_tx[idx+j] !== 4'd1 || lg_rx[idx+j] !== 3'd1) e4++;
    end
    idx += w + 1;
  endtask

  task automatic check_write(input int addr, input int len);
    int a = addr, r = len, k = 0, idx = 0, e1 = 0, e2 = 0, e3 = 0, e4 = 0, c;
    logic [31:0] expd;
    while (r > 0) begin
      if (idx + 1 >= lg_n) begin e1++; break; end
      c = (r < 4) ? r : 4;
      if (256 - (a % 256) < c) c = 256 - (a % 256);
      if (lg_op[idx] !== 8'h06 || lg_tx[idx] !== 4'd1) e2++;
      if (lg_op[idx+1] !== 8'h02 || lg_addr[idx+1] !== 24'(a) || lg_tx[idx+1] !== 4'(c + 4)) e1++;
      expd = '0;
      for (int j = 0; j < c; j++) expd = expd | (32'(sbuf[k+j]) << (8 * j));
      if (lg_data[idx+1] !== expd) e3++;
      idx += 2;
      check_polls(idx, e4, lg_wip[idx-1]);
      a += c; r -= c; k += c;
    end
    chk(e1 == 0 && idx == lg_n, "R1 chunk addresses and lengths", e1, 0);
    chk(e2 == 0, "R2 write-enable before program", e2, 0);
    chk(e3 == 0, "R3 packed program data", e3, 0);
    chk(e4 == 0, "R4 status polling after program", e4, 0);
    chk(gap_bad == 0 && gap_seen > 0, "R5 poll gap", gap_bad, 0);
  endtask

  task automatic check_erase(input int addr, input int len);
    int a = addr, idx = 0, e2 = 0, e4 = 0, e6 = 0;
    while (a < addr + len) begin
      if (idx + 1 >= lg_n) begin e6++; break; end
      if (lg_op[idx] !== 8'h06) e2++;
      if (lg_op[idx+1] !== 8'hD8 || lg_addr[idx+1] !== 24'(a) || lg_tx[idx+1] !== 4'd4) e6++;
      idx += 2;
      check_polls(idx, e4, lg_wip[idx-1]);
      a += SECT;
    end
    chk(e6 == 0 && idx == lg_n, "R6 sector walk", e6, 0);
    chk(e2 == 0, "R2 write-enable before erase", e2, 0);
    chk(e4 == 0, "R4 status polling after erase", e4, 0);
    chk(gap_bad == 0 && gap_seen > 0, "R5 poll gap", gap_bad, 0);
  endtask

  task automatic good_req(input bit er, input int addr, input int len);
    int lat; bit e;
    run_req(er, addr, len, lat, e);
    chk(!e && lat < 20000, "R7 in-range request accepted", e, 0);
    if (er) check_erase(addr, len); else check_write(addr, len);
  endtask

  task automatic bad_req(input bit er, input int addr, input int len, input bit expect_err);
    int lat; bit e;
    run_req(er, addr, len, lat, e);
    repeat (3) @(negedge clk);
    if (expect_err) begin
      chk(lat == 0 && e, "R7 refused at once with err", lat, 0);
      chk(lg_n == 0, "R7 no commands when refused", lg_n, 0);
    end else begin
      chk(lat == 0 && !e, "R8 zero length done at once", lat, 0);
      chk(lg_n == 0, "R8 no commands for zero length", lg_n, 0);
    end
  endtask

  initial begin
    int a, l;
    void'($urandom(32'd91357));
    repeat (5) @(negedge clk);
    rst_n = 1;
    @(negedge clk);
    chk(!done && !err && !cmd_valid && req_ready, "R9 reset state",
        {done, err, cmd_valid, req_ready}, 1);
    good_req(0, 32'h1FE, 7);
    good_req(0, 32'h13, 10);
    good_req(0, DEV - 4, 4);
    good_req(0, 32'h2FD, 1);
    bad_req(0, 32'h400, 0, 0);
    bad_req(1, 32'h10000, 0, 0);
    bad_req(0, DEV - 2, 3, 1);
    bad_req(1, 32'h3F0000, 32'h20000, 1);
    good_req(1, 32'h10000, 32'h20000);
    good_req(1, 0, 32'h10001);
    for (int i = 0; i < 16; i++) begin
      a = $urandom % DEV;
      if ($urandom % 3 == 0) a = (a & ~255) | (252 + $urandom % 4);
      l = 1 + $urandom % 40;
      if (a + l > DEV) a = DEV - l;
      good_req(0, a, l);
    end
    for (int i = 0; i < 4; i++) begin
      a = ($urandom % 60) * SECT + (($urandom % 2) ? $urandom % SECT : 0);
      l = 1 + $urandom % (3 * SECT);
      good_req(1, a, l);
    end
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
    $finish;
  end

  initial begin
    repeat (150000) @(posedge clk);
    n_cmp++; n_bad++;
    $display("FAIL watchdog expired actual=1 expected=0");
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
    $finish;
  end
endmodule